// File: doc/BRIEF.md
# ADC Sample Trigger Sequencer

This block holds one control word per sample slot and turns trigger events into conversion requests for a shared analog-to-digital converter. Each configurable slot picks one hardware trigger source: the external start pin, one of two end-of-conversion pulses, one of the timer overflow pulses, or one of the PWM trigger pulses. A per-slot software strobe always starts the slot, whatever source is selected. After a trigger, the slot waits a programmed number of ticks of a divided delay clock. It then raises a request that carries the analog channel number and the total length of the sampling window.

Each slot offers its request on a valid/ready pair. The request stays raised, with its channel and length held unchanged, until the arbiter raises ready in the same cycle. There is no buffering: while a request waits, a new trigger for that slot is dropped and reported. After its request is accepted, a slot reports completion when the converter signals end of conversion for that slot's index. The last three slots are fixed. Each one uses its own index as its channel, starts only from its software strobe and never waits a delay. Only their sampling extension can be written.

Top module: `adc_trig_seq`

## Requirements
- R1: While reset is held and in the first cycle after reset, every request valid, overrun and done output is low. Every control word resets to zero, which means software-only source, no delay, divide by 1, channel 0 and no extension.
- R2: Control word bits 23:16 select the hardware source. Code 0 selects none, 1 the external pin, 2 and 3 end-of-conversion pulse 0 and 1, 4 to 7 timer overflows 0 to 3, and 8 upward the PWM pulses 0 upward. A selected pulse seen at a rising edge triggers the slot, and the software strobe triggers it under any code.
- R3: Control word bit 5 enables rising edges and bit 4 enables falling edges of the external pin. The pin passes two synchroniser flops, so with no delay the request is valid after the third rising clock edge that follows the pin change. An edge of a kind that is not enabled has no effect.
- R4: While `conv_en` is low, every trigger is ignored: no request and no overrun.
- R5: Control word bits 15:8 hold the delay count N, and bits 7:6 select the divider D. Codes 0, 1, 2 and 3 select D = 1, 2, 4 and 16. With N = 0 the request is valid in the cycle after the triggering edge. Otherwise it becomes valid N*D cycles later than that.
- R6: A valid request stays valid with stable channel and length until ready is high in the same cycle. In the cycle after that acceptance it is low.
- R7: The request length is BASE_SMP plus the extension in control word bits 31:24. It is captured at the trigger.
- R8: A configurable slot's request channel is control word bits 3:0, captured at the trigger. Fixed slot k (k counts from 0) uses channel NUM_CFG+k, has no delay and starts only from its software strobe.
- R9: A trigger that arrives while the slot is counting its delay or holding its request is dropped. The slot's overrun output pulses for one cycle in the next cycle.
- R10: After a request is accepted, the next `conv_eoc` with `conv_eoc_slot` equal to the slot index pulses that slot's done output in the next cycle. An end-of-conversion report for a slot with no accepted request gives no pulse.
- R11: A control word write takes effect one cycle later. A trigger in the same cycle as the write uses the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_en | input | 1 | Global converter enable; triggers are accepted only while high |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_idx | input | 5 | Slot index for the write |
| cfg_data | input | 32 | Control word to write |
| sw_start | input | 19 | Per-slot software start strobe |
| ext_pin | input | 1 | Asynchronous external start pin |
| eoc_irq | input | 2 | End-of-conversion trigger pulses |
| tmr_ovf | input | 4 | Timer overflow pulses |
| pwm_trg | input | 12 | PWM trigger pulses |
| req_valid | output | 19 | Per-slot conversion request valid |
| req_ready | input | 19 | Per-slot grant from the arbiter |
| req_chan | output | 19x5 | Per-slot requested channel |
| req_smp | output | 19x9 | Per-slot sampling length in ADC clocks |
| conv_eoc | input | 1 | Converter end-of-conversion strobe |
| conv_eoc_slot | input | 5 | Slot index of the finished conversion |
| slot_overrun | output | 19 | Per-slot dropped-trigger pulse |
| slot_done | output | 19 | Per-slot conversion-done pulse |

## Verification
A wrong prescaler or delay count shows up as a request that rises in the wrong cycle. The shift is a whole number of divided ticks, so it is seen at the very cycle of the expected rise. A wrong capture of the channel or length shows on the request outputs in the first cycle they are valid. A lost completion flag shows as a missing or extra done pulse in the cycle after the end-of-conversion report. A mistracked busy state shows as a wrongly accepted trigger, or a wrongly dropped one, in the next cycle through `slot_overrun` or `req_valid`. The reference model is compared with every output on every clock, so each fault is caught in the first cycle it becomes visible.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  // control word layout
  localparam int CHF_W     = 4;
  localparam int CH_LSB    = 0;
  localparam int FEN_BIT   = 4;
  localparam int REN_BIT   = 5;
  localparam int DIV_LSB   = 6;
  localparam int DLY_LSB   = 8;
  localparam int DLY_W     = 8;
  localparam int SEL_LSB   = 16;
  localparam int SEL_W     = 8;
  localparam int EXT_LSB   = 24;
  localparam int EXT_W     = 8;
  localparam int CFG_W     = 32;
  localparam int SMP_W     = EXT_W + 1;
  localparam int PRE_W     = 4;

  // source codes
  localparam int SEL_PIN   = 1;
  localparam int SEL_EOC0  = 2;
  localparam int NUM_EOC   = 2;
  localparam int SEL_TMR0  = SEL_EOC0 + NUM_EOC;

  typedef enum logic [1:0] {
    SL_IDLE  = 2'd0,
    SL_DELAY = 2'd1,
    SL_REQ   = 2'd2
  } slot_st_e;

  // reload value of the delay prescaler: divider minus one
  function automatic logic [PRE_W-1:0] div_reload(input logic [1:0] code);
    case (code)
      2'd0:    return PRE_W'(0);
      2'd1:    return PRE_W'(1);
      2'd2:    return PRE_W'(3);
      default: return PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/adc_trig_pin_sync.sv
module adc_trig_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh[0], sh[1] synchronise; sh[2] is the previous synchronised value
  logic [2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], pin_i};
  end

  assign rise_o =  sh_q[1] & ~sh_q[2];
  assign fall_o = ~sh_q[1] &  sh_q[2];
endmodule

// File: rtl/adc_trig_src_mux.sv
module adc_trig_src_mux
  import adc_trig_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int NUM_PWM = 12
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               fen_i,
  input  logic               ren_i,
  input  logic               pin_rise_i,
  input  logic               pin_fall_i,
  input  logic [NUM_EOC-1:0] eoc_irq_i,
  input  logic [NUM_TMR-1:0] tmr_i,
  input  logic [NUM_PWM-1:0] pwm_i,
  output logic               hit_o
);
  localparam int SEL_PWM0 = SEL_TMR0 + NUM_TMR;

  always_comb begin
    hit_o = 1'b0;
    if (int'(sel_i) == SEL_PIN)
      hit_o = (pin_rise_i & ren_i) | (pin_fall_i & fen_i);
    for (int k = 0; k < NUM_EOC; k++)
      if (int'(sel_i) == SEL_EOC0 + k) hit_o = eoc_irq_i[k];
    for (int k = 0; k < NUM_TMR; k++)
      if (int'(sel_i) == SEL_TMR0 + k) hit_o = tmr_i[k];
    for (int k = 0; k < NUM_PWM; k++)
      if (int'(sel_i) == SEL_PWM0 + k) hit_o = pwm_i[k];
  end
endmodule

// File: rtl/adc_trig_slot.sv
module adc_trig_slot
  import adc_trig_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [1:0]       div_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             req_ready_i,
  input  logic             eoc_hit_i,
  output logic             req_valid_o,
  output logic [CH_W-1:0]  req_chan_o,
  output logic [SMP_W-1:0] req_smp_o,
  output logic             ovr_o,
  output logic             done_o
);
  slot_st_e         st_q;
  logic [DLY_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] reload_q;
  logic [CH_W-1:0]  chan_q;
  logic [SMP_W-1:0] smp_q;
  logic             wait_q;
  logic             ovr_q;
  logic             done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= SL_IDLE;
      cnt_q    <= '0;
      pre_q    <= '0;
      reload_q <= '0;
      chan_q   <= '0;
      smp_q    <= '0;
      wait_q   <= 1'b0;
      ovr_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
      if (eoc_hit_i && wait_q) begin
        done_q <= 1'b1;
        wait_q <= 1'b0;
      end
      unique case (st_q)
        SL_IDLE: begin
          if (trig_i) begin
            chan_q   <= chan_i;
            smp_q    <= smp_i;
            cnt_q    <= dly_i;
            reload_q <= div_reload(div_i);
            pre_q    <= div_reload(div_i);
            st_q     <= (dly_i == '0) ? SL_REQ : SL_DELAY;
          end
        end
        SL_DELAY: begin
          if (trig_i) ovr_q <= 1'b1;
          if (pre_q == '0) begin
            pre_q <= reload_q;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == DLY_W'(1)) st_q <= SL_REQ;
          end else begin
            pre_q <= pre_q - 1'b1;
          end
        end
        SL_REQ: begin
          if (trig_i) ovr_q <= 1'b1;
          if (req_ready_i) begin
            st_q   <= SL_IDLE;
            wait_q <= 1'b1;
          end
        end
        default: st_q <= SL_IDLE;
      endcase
    end
  end

  assign req_valid_o = (st_q == SL_REQ);
  assign req_chan_o  = chan_q;
  assign req_smp_o   = smp_q;
  assign ovr_o       = ovr_q;
  assign done_o      = done_q;
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int NUM_CFG  = 16,
  parameter int NUM_FIX  = 3,
  parameter int NUM_TMR  = 4,
  parameter int NUM_PWM  = 12,
  parameter int BASE_SMP = 6,
  localparam int NSLOT   = NUM_CFG + NUM_FIX,
  localparam int IDX_W   = $clog2(NSLOT),
  localparam int CH_W    = $clog2(NSLOT)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              conv_en,
  input  logic                              cfg_wr,
  input  logic [IDX_W-1:0]                  cfg_idx,
  input  logic [CFG_W-1:0]                  cfg_data,
  input  logic [NSLOT-1:0]                  sw_start,
  input  logic                              ext_pin,
  input  logic [NUM_EOC-1:0]                eoc_irq,
  input  logic [NUM_TMR-1:0]                tmr_ovf,
  input  logic [NUM_PWM-1:0]                pwm_trg,
  output logic [NSLOT-1:0]                  req_valid,
  input  logic [NSLOT-1:0]                  req_ready,
  output logic [NSLOT-1:0][CH_W-1:0]        req_chan,
  output logic [NSLOT-1:0][SMP_W-1:0]       req_smp,
  input  logic                              conv_eoc,
  input  logic [IDX_W-1:0]                  conv_eoc_slot,
  output logic [NSLOT-1:0]                  slot_overrun,
  output logic [NSLOT-1:0]                  slot_done
);
  logic pin_rise, pin_fall;

  adc_trig_pin_sync u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic             wr_me;
    logic             trig;
    logic [DLY_W-1:0] dly;
    logic [1:0]       dv;
    logic [CH_W-1:0]  ch;
    logic [EXT_W-1:0] ext_q;
    logic [SMP_W-1:0] smp;

    assign wr_me = cfg_wr && (cfg_idx == IDX_W'(g));
    assign smp   = SMP_W'(BASE_SMP) + SMP_W'(ext_q);

    if (g < NUM_CFG) begin : g_cfg
      logic [CHF_W-1:0] ch_q;
      logic             fen_q, ren_q;
      logic [1:0]       div_q;
      logic [DLY_W-1:0] dly_q;
      logic [SEL_W-1:0] sel_q;
      logic             hit;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ch_q  <= '0;
          fen_q <= 1'b0;
          ren_q <= 1'b0;
          div_q <= '0;
          dly_q <= '0;
          sel_q <= '0;
          ext_q <= '0;
        end else if (wr_me) begin
          ch_q  <= cfg_data[CH_LSB  +: CHF_W];
          fen_q <= cfg_data[FEN_BIT];
          ren_q <= cfg_data[REN_BIT];
          div_q <= cfg_data[DIV_LSB +: 2];
          dly_q <= cfg_data[DLY_LSB +: DLY_W];
          sel_q <= cfg_data[SEL_LSB +: SEL_W];
          ext_q <= cfg_data[EXT_LSB +: EXT_W];
        end
      end

      adc_trig_src_mux #(
        .NUM_TMR (NUM_TMR),
        .NUM_PWM (NUM_PWM)
      ) u_mux (
        .sel_i      (sel_q),
        .fen_i      (fen_q),
        .ren_i      (ren_q),
        .pin_rise_i (pin_rise),
        .pin_fall_i (pin_fall),
        .eoc_irq_i  (eoc_irq),
        .tmr_i      (tmr_ovf),
        .pwm_i      (pwm_trg),
        .hit_o      (hit)
      );

      assign trig = conv_en & (sw_start[g] | hit);
      assign dly  = dly_q;
      assign dv   = div_q;
      assign ch   = CH_W'(ch_q);
    end else begin : g_fix
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ext_q <= '0;
        else if (wr_me) ext_q <= cfg_data[EXT_LSB +: EXT_W];
      end

      assign trig = conv_en & sw_start[g];
      assign dly  = '0;
      assign dv   = 2'd0;
      assign ch   = CH_W'(g);
    end

    adc_trig_slot #(
      .CH_W (CH_W)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .dly_i       (dly),
      .div_i       (dv),
      .chan_i      (ch),
      .smp_i       (smp),
      .req_ready_i (req_ready[g]),
      .eoc_hit_i   (conv_eoc && (conv_eoc_slot == IDX_W'(g))),
      .req_valid_o (req_valid[g]),
      .req_chan_o  (req_chan[g]),
      .req_smp_o   (req_smp[g]),
      .ovr_o       (slot_overrun[g]),
      .done_o      (slot_done[g])
    );
  end
endmodule

// File: rtl/adc_trig_seq_chk.sv
module adc_trig_seq_chk
  import adc_trig_pkg::*;
#(
  parameter int NUM_CFG  = 16,
  parameter int NUM_FIX  = 3,
  parameter int BASE_SMP = 6,
  localparam int NSLOT   = NUM_CFG + NUM_FIX,
  localparam int IDX_W   = $clog2(NSLOT),
  localparam int CH_W    = $clog2(NSLOT)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        conv_en,
  input logic [NSLOT-1:0]            sw_start,
  input logic [NSLOT-1:0]            req_valid,
  input logic [NSLOT-1:0]            req_ready,
  input logic [NSLOT-1:0][CH_W-1:0]  req_chan,
  input logic [NSLOT-1:0][SMP_W-1:0] req_smp,
  input logic                        conv_eoc,
  input logic [IDX_W-1:0]            conv_eoc_slot,
  input logic [NSLOT-1:0]            slot_overrun,
  input logic [NSLOT-1:0]            slot_done
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_a
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[g] && !req_ready[g] |=> req_valid[g] && $stable(req_chan[g]) && $stable(req_smp[g]));

    assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[g] && req_ready[g] |=> !req_valid[g]);

    assert_smp_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[g] |-> req_smp[g] >= SMP_W'(BASE_SMP));

    assert_done_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
      slot_done[g] |-> $past(conv_eoc) && ($past(conv_eoc_slot) == IDX_W'(g)));

    assert_ovr_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_overrun[g] |-> $past(conv_en));

    if (g >= NUM_CFG) begin : g_fix
      assert_fix_chan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[g] |-> req_chan[g] == CH_W'(g));

      assert_fix_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid[g]) |-> $past(sw_start[g]) && $past(conv_en));
    end
  end
endmodule

bind adc_trig_seq adc_trig_seq_chk #(
  .NUM_CFG  (NUM_CFG),
  .NUM_FIX  (NUM_FIX),
  .BASE_SMP (BASE_SMP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .conv_en       (conv_en),
  .sw_start      (sw_start),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_chan      (req_chan),
  .req_smp       (req_smp),
  .conv_eoc      (conv_eoc),
  .conv_eoc_slot (conv_eoc_slot),
  .slot_overrun  (slot_overrun),
  .slot_done     (slot_done)
);

// File: tb/test_adc_trig_seq.sv
module test_adc_trig_seq;
  localparam int NCFG = 16;
  localparam int NSL  = 19;
  localparam int NTMR = 4;
  localparam int NPWM = 12;
  localparam int BASE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic conv_en = 1'b0;
  logic cfg_wr = 1'b0;
  logic [4:0] cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic [NSL-1:0] sw_start = '0;
  logic ext_pin = 1'b0;
  logic [1:0] eoc_irq = '0;
  logic [NTMR-1:0] tmr_ovf = '0;
  logic [NPWM-1:0] pwm_trg = '0;
  logic [NSL-1:0] req_valid;
  logic [NSL-1:0] req_ready = '1;
  logic [NSL-1:0][4:0] req_chan;
  logic [NSL-1:0][8:0] req_smp;
  logic conv_eoc = 1'b0;
  logic [4:0] conv_eoc_slot = '0;
  logic [NSL-1:0] slot_overrun;
  logic [NSL-1:0] slot_done;

  always #10 clk = ~clk;

  adc_trig_seq i_adc_trig_seq (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .sw_start(sw_start), .ext_pin(ext_pin), .eoc_irq(eoc_irq),
    .tmr_ovf(tmr_ovf), .pwm_trg(pwm_trg), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_smp(req_smp), .conv_eoc(conv_eoc),
    .conv_eoc_slot(conv_eoc_slot), .slot_overrun(slot_overrun), .slot_done(slot_done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cfg [NSL];
  int m_st [NSL];      // 0 idle, 1 counting, 2 requesting
  int m_left [NSL];
  int m_ch [NSL];
  int m_smp [NSL];
  bit m_wait [NSL];
  bit e_ovr [NSL];
  bit e_done [NSL];
  bit p1, p2, p3;

  function automatic int divider(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 16;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1 = 0; p2 = 0; p3 = 0;
      for (int i = 0; i < NSL; i++) begin
        m_cfg[i] = '0; m_st[i] = 0; m_left[i] = 0; m_ch[i] = 0; m_smp[i] = 0;
        m_wait[i] = 0; e_ovr[i] = 0; e_done[i] = 0;
      end
    end else begin
      bit rise, fall;
      rise = p2 && !p3;
      fall = !p2 && p3;
      p3 = p2; p2 = p1; p1 = ext_pin;
      for (int i = 0; i < NSL; i++) begin
        bit hw, trig;
        int sel, n, d, ch;
        hw = 0;
        sel = int'(m_cfg[i][23:16]);
        n = (i < NCFG) ? int'(m_cfg[i][15:8]) : 0;
        d = divider(m_cfg[i][7:6]);
        ch = (i < NCFG) ? int'(m_cfg[i][3:0]) : i;
        if (i < NCFG) begin
          if (sel == 1) hw = (rise && m_cfg[i][5]) || (fall && m_cfg[i][4]);
          else if (sel >= 2 && sel < 4) hw = eoc_irq[sel-2];
          else if (sel >= 4 && sel < 4 + NTMR) hw = tmr_ovf[sel-4];
          else if (sel >= 8 && sel < 8 + NPWM) hw = pwm_trg[sel-8];
        end
        trig = conv_en && (sw_start[i] || hw);
        e_ovr[i] = 0;
        e_done[i] = 0;
        if (conv_eoc && int'(conv_eoc_slot) == i && m_wait[i]) begin
          e_done[i] = 1; m_wait[i] = 0;
        end
        if (m_st[i] == 0) begin
          if (trig) begin
            m_ch[i] = ch;
            m_smp[i] = BASE + int'(m_cfg[i][31:24]);
            m_left[i] = n * d;
            m_st[i] = (n == 0) ? 2 : 1;
          end
        end else if (m_st[i] == 1) begin
          if (trig) e_ovr[i] = 1;
          m_left[i]--;
          if (m_left[i] == 0) m_st[i] = 2;
        end else begin
          if (trig) e_ovr[i] = 1;
          if (req_ready[i]) begin m_st[i] = 0; m_wait[i] = 1; end
        end
      end
      if (cfg_wr && int'(cfg_idx) < NSL) m_cfg[cfg_idx] = cfg_data;
    end
  end

  // compare every output on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NSL; i++) begin
        chk(req_valid[i] == (m_st[i] == 2), "R6", $sformatf("req_valid[%0d]", i), req_valid[i], m_st[i] == 2);
        if (m_st[i] == 2) begin
          chk(int'(req_chan[i]) == m_ch[i], "R8", $sformatf("req_chan[%0d]", i), req_chan[i], m_ch[i]);
          chk(int'(req_smp[i]) == m_smp[i], "R7", $sformatf("req_smp[%0d]", i), req_smp[i], m_smp[i]);
        end
        chk(slot_overrun[i] == e_ovr[i], "R9", $sformatf("slot_overrun[%0d]", i), slot_overrun[i], e_ovr[i]);
        chk(slot_done[i] == e_done[i], "R10", $sformatf("slot_done[%0d]", i), slot_done[i], e_done[i]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual=%0d expected<%0d", cyc, 150000);
      summary();
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_cfg(input int idx, input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 5'(idx); cfg_data = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  function automatic logic [31:0] word(input int ext, input int sel, input int dly,
                                       input int dv, input int ren, input int fen, input int ch);
    return {8'(ext), 8'(sel), 8'(dly), 2'(dv), 1'(ren), 1'(fen), 4'(ch)};
  endfunction

  // kind: 0 software strobe, 1 end-of-conversion pulse, 2 timer, 3 PWM
  task automatic fire_and_time(input int s, input int kind, input int b, output int lat);
    @(negedge clk);
    case (kind)
      0: sw_start[b] = 1'b1;
      1: eoc_irq[b]  = 1'b1;
      2: tmr_ovf[b]  = 1'b1;
      default: pwm_trg[b] = 1'b1;
    endcase
    @(negedge clk);
    sw_start = '0; eoc_irq = '0; tmr_ovf = '0; pwm_trg = '0;
    lat = 1;
    while (!req_valid[s] && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic pin_and_time(input int s, input logic lvl, output int lat);
    @(negedge clk);
    ext_pin = lvl;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_valid[s] && lat < 8);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(req_valid == '0 && slot_overrun == '0 && slot_done == '0, "R1", "outputs in reset",
        int'(req_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_valid == '0 && slot_overrun == '0 && slot_done == '0, "R1", "outputs after reset",
        int'(req_valid), 0);
    conv_en = 1'b1;

    // R5: reset word gives no delay; request one cycle after trigger
    fire_and_time(0, 0, 0, lat);
    chk(lat == 1, "R5", "latency delay 0", lat, 1);
    chk(int'(req_smp[0]) == BASE, "R1", "reset extension", req_smp[0], BASE);

    // R10: completion after acceptance
    @(negedge clk); conv_eoc = 1'b1; conv_eoc_slot = 5'd0;
    @(negedge clk); conv_eoc = 1'b0;
    chk(slot_done[0], "R10", "done after eoc", slot_done[0], 1);
    @(negedge clk); conv_eoc = 1'b1; conv_eoc_slot = 5'd9;
    @(negedge clk); conv_eoc = 1'b0;
    chk(!slot_done[9], "R10", "no done without grant", slot_done[9], 0);

    // R5: divider 16, count 3
    wr_cfg(2, word(3, 0, 3, 3, 0, 0, 12));
    fire_and_time(2, 0, 2, lat);
    chk(lat == 49, "R5", "latency N=3 D=16", lat, 49);
    chk(int'(req_chan[2]) == 12, "R8", "channel field", req_chan[2], 12);
    // R5: divider 2, count 5
    wr_cfg(3, word(0, 0, 5, 1, 0, 0, 3));
    fire_and_time(3, 0, 3, lat);
    chk(lat == 11, "R5", "latency N=5 D=2", lat, 11);

    // R9: retrigger during delay is dropped
    @(negedge clk); sw_start[2] = 1'b1;
    @(negedge clk); sw_start[2] = 1'b0;
    repeat (4) @(negedge clk);
    sw_start[2] = 1'b1;
    @(negedge clk); sw_start[2] = 1'b0;
    chk(slot_overrun[2], "R9", "overrun during delay", slot_overrun[2], 1);
    repeat (50) @(negedge clk);

    // R3: rising edge on pin, slot 1 rising only; slot 4 falling only
    wr_cfg(1, word(0, 1, 0, 0, 1, 0, 1));
    wr_cfg(4, word(0, 1, 0, 0, 0, 1, 4));
    pin_and_time(1, 1'b1, lat);
    chk(lat == 3, "R3", "pin rising latency", lat, 3);
    pin_and_time(4, 1'b0, lat);
    chk(lat == 3, "R3", "pin falling latency", lat, 3);
    chk(!req_valid[1], "R3", "falling edge ignored by rising-only slot", req_valid[1], 0);

    // R2: other sources
    wr_cfg(5, word(1, 3, 0, 0, 0, 0, 5));
    wr_cfg(6, word(2, 6, 0, 0, 0, 0, 6));
    wr_cfg(7, word(4, 11, 0, 0, 0, 0, 7));
    fire_and_time(5, 1, 1, lat);
    chk(lat == 1, "R2", "eoc1 source", lat, 1);
    fire_and_time(6, 2, 2, lat);
    chk(lat == 1, "R2", "timer2 source", lat, 1);
    fire_and_time(7, 3, 3, lat);
    chk(lat == 1, "R2", "pwm3 source", lat, 1);
    fire_and_time(6, 2, 0, lat);
    chk(lat == 400, "R2", "unselected timer ignored", lat, 400);

    // R4: disabled converter
    conv_en = 1'b0;
    @(negedge clk); sw_start[0] = 1'b1;
    @(negedge clk); sw_start[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk(!req_valid[0] && !slot_overrun[0], "R4", "trigger with enable low", req_valid[0], 0);
    conv_en = 1'b1;

    // R6: hold while not ready, then R9 during request
    req_ready[0] = 1'b0;
    fire_and_time(0, 0, 0, lat);
    repeat (3) @(negedge clk);
    chk(req_valid[0], "R6", "held without ready", req_valid[0], 1);
    sw_start[0] = 1'b1;
    @(negedge clk); sw_start[0] = 1'b0;
    chk(slot_overrun[0], "R9", "overrun while requesting", slot_overrun[0], 1);
    req_ready[0] = 1'b1;
    @(negedge clk);
    chk(!req_valid[0], "R6", "dropped after accept", req_valid[0], 1'b0);

    // R8: fixed slot 17
    wr_cfg(17, word(20, 0, 9, 3, 1, 1, 2));
    fire_and_time(17, 0, 17, lat);
    chk(lat == 1 && int'(req_chan[17]) == 17, "R8", "fixed slot channel", req_chan[17], 17);
    chk(int'(req_smp[17]) == BASE + 20, "R7", "fixed slot length", req_smp[17], BASE + 20);

    // R11: write and trigger in one cycle use the old word
    @(negedge clk);
    cfg_wr = 1'b1; cfg_idx = 5'd9; cfg_data = word(7, 0, 0, 0, 0, 0, 9);
    sw_start[9] = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; sw_start[9] = 1'b0;
    chk(req_valid[9] && int'(req_smp[9]) == BASE, "R11", "old word at write", req_smp[9], BASE);
    fire_and_time(9, 0, 9, lat);
    chk(int'(req_smp[9]) == BASE + 7, "R11", "new word after write", req_smp[9], BASE + 7);

    repeat (5) @(negedge clk);
    summary();
  end
endmodule